// File: doc/BRIEF.md
# Configuration-Memory Serial Bus Target

This block is a byte-addressed target on a two-wire serial bus (I2C). It holds a 256-byte configuration memory that describes a memory module to the host. The host reaches it through SCL and SDA, with SDA modelled as an open-drain line: an input level plus an output enable that pulls the line low. Three strap inputs set the low bits of the bus address, so several modules can share one bus.

The host first writes a one-byte word address. After that it can store one or more data bytes, or it can issue a repeated start and read bytes one after another. The word pointer steps after every data byte. The lower 128 bytes are locked at production and cannot be changed afterwards. The upper 128 bytes stay writable unless the write-protect input is high. Reset loads the memory from a parameter image, and byte 63 is always loaded with a checksum computed over bytes 0 to 62. Both bus lines are oversampled by the system clock.

Top module: `spd_target`

## Requirements
- R1: The target acknowledges only the 7-bit address formed as binary 1010 in the upper four bits and `strap_i[2:0]` in the lower three bits. For any other address it drives nothing until the next start or stop.
- R2: After reset, the default image holds 0x80 in byte 0 and 0x08 in byte 1. Bytes 2 to 62 hold their own index, and bytes 64 to 255 hold 0x00. Byte 63 holds the low 8 bits of the sum of bytes 0 to 62, which is 0x28 for the default image.
- R3: In a write transfer, the first byte after the address byte sets the word pointer. A later read, with or without a repeated start, returns the byte at that pointer.
- R4: A data byte written to an address at 128 or above is acknowledged and stored, and the pointer then steps by one.
- R5: A data byte written to an address below 128 (address bit 7 clear) is acknowledged but not stored.
- R6: While `wp_i` is high, every data byte is acknowledged but not stored.
- R7: A sequential read returns consecutive bytes, and the pointer wraps from 255 to 0.
- R8: When the host does not acknowledge a read byte, the target releases SDA. It keeps SDA released through further SCL pulses until a start or stop.
- R9: A stop condition at any point returns the target to idle with SDA released. A data byte that was only partly received is discarded.
- R10: A start condition in the middle of a transfer abandons that transfer and begins a new address decode. The word pointer keeps its last value.
- R11: SDA is released after reset and whenever the target is idle.
- R12: The target changes its SDA drive only while SCL is low. The one exception is releasing SDA on a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | When high, the target pulls SDA low |
| strap_i | input | 3 | Board strap pins forming the low three address bits |
| wp_i | input | 1 | Write protect; when high, all writes are dropped |

## Verification
Two pairs of functions can land in the same clock cycle.

The first pair is the storing of a data byte and the gate that decides whether it may be stored. Both act on the falling SCL edge that follows the eighth data bit, and the pointer steps on that same edge. The bench provokes this with writes to the highest unlocked address, to locked addresses and under write protect. It then reads back through the bus and compares the result against a behavioural byte-array model.

The second pair is an abort condition (a start or stop) against a byte that is partly shifted in. The bench cuts a data byte after four bits with a stop, and in a separate case with a repeated start. It then checks that memory is unchanged and that the pointer still holds the word address.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int ADDR_W    = 8;
  localparam int MEM_BYTES = 1 << ADDR_W;
  localparam int SUM_LAST  = 62;
  localparam int SUM_SLOT  = 63;
  localparam logic [3:0] DEV_ID = 4'b1010;

  typedef logic [7:0] image_t [MEM_BYTES];

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_WADDR, S_WADDR_ACK,
    S_WDATA, S_WDATA_ACK, S_RDATA, S_RACK, S_WAIT_STOP
  } spd_state_e;

  function automatic image_t default_image();
    image_t img;
    for (int i = 0; i < MEM_BYTES; i++)
      img[i] = (i >= 2 && i <= SUM_LAST) ? 8'(i) : 8'h00;
    img[0] = 8'h80;
    img[1] = 8'h08;
    return img;
  endfunction

  // byte SUM_SLOT replaced by the 8-bit sum of bytes 0..SUM_LAST
  function automatic image_t seal_image(image_t src);
    image_t img = src;
    logic [7:0] acc = 8'h00;
    for (int i = 0; i <= SUM_LAST; i++) acc = acc + src[i];
    img[SUM_SLOT] = acc;
    return img;
  endfunction
endpackage

// File: rtl/spd_sync.sv
module spd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] scl_pipe, sda_pipe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[LAST-1:0], scl_i};
      sda_pipe <= {sda_pipe[LAST-1:0], sda_i};
    end
  end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now = scl_pipe[LAST-1];
  assign scl_old = scl_pipe[LAST];
  assign sda_now = sda_pipe[LAST-1];
  assign sda_old = sda_pipe[LAST];

  assign scl_o      = scl_now;
  assign sda_o      = sda_now;
  assign scl_rise_o = scl_now & ~scl_old;
  assign scl_fall_o = ~scl_now & scl_old;
  assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/spd_mem.sv
module spd_mem
  import spd_pkg::*;
#(
  parameter image_t INIT_IMAGE = default_image(),
  parameter bit     LOCK_LOWER = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              wp_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam image_t RST_IMAGE = seal_image(INIT_IMAGE);

  logic [7:0] store [MEM_BYTES];
  logic       locked_hit, wr_ok;

  assign locked_hit = LOCK_LOWER && !wr_addr_i[ADDR_W-1];
  assign wr_ok      = wr_req_i && !wp_i && !locked_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_BYTES; i++) store[i] <= RST_IMAGE[i];
    end else if (wr_ok) begin
      store[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = store[rd_addr_i];
endmodule

// File: rtl/spd_ctrl.sv
module spd_ctrl
  import spd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [2:0]        strap_i,
  input  logic [7:0]        rd_data_i,
  output logic              sda_oe_o,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [7:0]        wr_data_o,
  output spd_state_e        state_o
);
  spd_state_e        state_q;
  logic [3:0]        cnt_q;
  logic [7:0]        shift_q, tx_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              oe_q, rw_q, mack_q;
  logic              rx_state, byte_done;

  assign rx_state  = (state_q == S_DEV) || (state_q == S_WADDR) || (state_q == S_WDATA);
  assign byte_done = (cnt_q == 4'd8);
  assign wr_req_o  = scl_fall_i && !start_i && !stop_i && (state_q == S_WDATA) && byte_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else if (stop_i) begin
      state_q <= S_IDLE;
      oe_q    <= 1'b0;
    end else if (start_i) begin
      state_q <= S_DEV;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      if (scl_rise_i) begin
        if (rx_state) begin
          shift_q <= {shift_q[6:0], sda_i};
          cnt_q   <= cnt_q + 4'd1;
        end
        if (state_q == S_RDATA) cnt_q <= cnt_q + 4'd1;
        if (state_q == S_RACK)  mack_q <= !sda_i;
      end
      if (scl_fall_i) begin
        case (state_q)
          S_DEV: if (byte_done) begin
            if (shift_q[7:1] == {DEV_ID, strap_i}) begin
              oe_q    <= 1'b1;
              rw_q    <= shift_q[0];
              state_q <= S_DEV_ACK;
            end else begin
              state_q <= S_WAIT_STOP;
            end
          end
          S_DEV_ACK: begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q    <= rd_data_i;
              oe_q    <= !rd_data_i[7];
              state_q <= S_RDATA;
            end else begin
              oe_q    <= 1'b0;
              state_q <= S_WADDR;
            end
          end
          S_WADDR: if (byte_done) begin
            ptr_q   <= shift_q;
            oe_q    <= 1'b1;
            state_q <= S_WADDR_ACK;
          end
          S_WADDR_ACK, S_WDATA_ACK: begin
            oe_q    <= 1'b0;
            cnt_q   <= '0;
            state_q <= S_WDATA;
          end
          S_WDATA: if (byte_done) begin
            ptr_q   <= ptr_q + 1'b1;
            oe_q    <= 1'b1;
            state_q <= S_WDATA_ACK;
          end
          S_RDATA: begin
            if (byte_done) begin
              oe_q    <= 1'b0;
              ptr_q   <= ptr_q + 1'b1;
              state_q <= S_RACK;
            end else begin
              tx_q <= {tx_q[6:0], 1'b1};
              oe_q <= !tx_q[6];
            end
          end
          S_RACK: begin
            if (mack_q) begin
              tx_q    <= rd_data_i;
              oe_q    <= !rd_data_i[7];
              cnt_q   <= '0;
              state_q <= S_RDATA;
            end else begin
              state_q <= S_WAIT_STOP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign ptr_o     = ptr_q;
  assign wr_data_o = shift_q;
  assign state_o   = state_q;
endmodule

// File: rtl/spd_target.sv
module spd_target
  import spd_pkg::*;
#(
  parameter int     SYNC_STAGES = 2,
  parameter bit     LOCK_LOWER  = 1'b1,
  parameter image_t INIT_IMAGE  = default_image()
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic              wr_req;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        wr_data, rd_data;
  spd_state_e        state;

  spd_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_lvl), .sda_o(sda_lvl),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  spd_ctrl ctrl_i (
    .clk_i, .rst_ni,
    .sda_i(sda_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_evt), .stop_i(stop_evt),
    .strap_i, .rd_data_i(rd_data),
    .sda_oe_o, .wr_req_o(wr_req), .ptr_o(ptr),
    .wr_data_o(wr_data), .state_o(state)
  );

  spd_mem #(.INIT_IMAGE(INIT_IMAGE), .LOCK_LOWER(LOCK_LOWER)) mem_i (
    .clk_i, .rst_ni,
    .wr_req_i(wr_req), .wr_addr_i(ptr), .wr_data_i(wr_data), .wp_i,
    .rd_addr_i(ptr), .rd_data_o(rd_data)
  );
endmodule

// File: rtl/spd_target_chk.sv
module spd_target_chk
  import spd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sda_oe_i,
  input logic              scl_lvl_i,
  input logic              start_i,
  input logic              stop_i,
  input logic              wr_req_i,
  input logic [ADDR_W-1:0] ptr_i,
  input spd_state_e        state_i
);
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_IDLE |-> !sda_oe_i);

  p_stop_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!sda_oe_i && state_i == S_IDLE));

  p_nack_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_WAIT_STOP |-> !sda_oe_i);

  p_ptr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i |=> ptr_i == $past(ptr_i) + 1'b1);

  p_start_decode_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_i == S_DEV && ptr_i == $past(ptr_i)));

  p_drive_scl_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> (!scl_lvl_i || $past(start_i || stop_i)));
endmodule

bind spd_target spd_target_chk chk_i (
  .clk_i, .rst_ni, .sda_oe_i(sda_oe_o), .scl_lvl_i(scl_lvl),
  .start_i(start_evt), .stop_i(stop_evt), .wr_req_i(wr_req),
  .ptr_i(ptr), .state_i(state)
);

// File: tb/spd_target_tb.sv
module spd_target_tb_top;
  localparam int Q     = 8;
  localparam int LIMIT = 150000;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       host_scl = 1'b1, host_sda = 1'b1;
  logic [2:0] strap = 3'b011;
  logic       wp = 1'b0;
  logic       sda_oe, sda_bus;
  int         tests = 0, fails = 0, viol_quiet = 0, viol_edge = 0;
  bit         quiet = 1'b1;
  int         model [256];

  always #2ns clk = ~clk;

  assign sda_bus = host_sda & ~sda_oe;

  spd_target dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(host_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .strap_i(strap), .wp_i(wp)
  );

  // per-clock comparison against the model's expectation of bus drive
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (quiet && sda_oe) viol_quiet++;
      if (sda_oe != prev_oe && host_scl && sda_oe) viol_edge++;
    end
    prev_oe <= sda_oe;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; tick(Q);
    host_scl = 1'b1; tick(Q);
    host_sda = 1'b0; tick(Q);
    host_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; tick(Q);
    host_scl = 1'b1; tick(Q);
    host_sda = 1'b1; tick(Q);
    quiet = 1'b1;
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    quiet = 1'b1;
    for (int i = 7; i > 7 - n; i--) begin
      host_sda = b[i]; tick(Q);
      host_scl = 1'b1; tick(2 * Q);
      if (i == 0) quiet = 1'b0;
      host_scl = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack);
    send_bits(b, 8);
    host_sda = 1'b1; tick(Q);
    host_scl = 1'b1; tick(Q);
    ack = !sda_bus; tick(Q);
    host_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(bit give_ack, output logic [7:0] b);
    quiet = 1'b0;
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      host_scl = 1'b1; tick(Q);
      b[i] = sda_bus; tick(Q);
      host_scl = 1'b0;
    end
    tick(Q);
    host_sda = !give_ack; tick(Q);
    host_scl = 1'b1; tick(2 * Q);
    host_scl = 1'b0; tick(Q);
    host_sda = 1'b1;
    if (!give_ack) quiet = 1'b1;
  endtask

  function automatic logic [7:0] dev(bit rd);
    return {4'b1010, strap, rd};
  endfunction

  // model write: stores only at unlocked address and with protect low
  task automatic write_seq(int addr, int n, int d0, int step, string req);
    bit ack;
    int a = addr;
    bus_start();
    send_byte(dev(0), ack); check(ack, req, "dev ack on write", ack, 1);
    send_byte(8'(addr), ack); check(ack, req, "word address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = 8'(d0 + k * step);
      send_byte(d, ack);
      check(ack, req, "data ack", ack, 1);
      if (!wp && a >= 128) model[a] = d;
      a = (a + 1) % 256;
    end
    bus_stop();
  endtask

  task automatic read_seq(int addr, int n, string req);
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte(dev(0), ack);
    send_byte(8'(addr), ack);
    bus_start();
    send_byte(dev(1), ack); check(ack, req, "dev ack on read", ack, 1);
    for (int k = 0; k < n; k++) begin
      int a = (addr + k) % 256;
      recv_byte(k != n - 1, b);
      check(b == 8'(model[a]), req, $sformatf("byte %0d", a), b, model[a]);
    end
    bus_stop();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", LIMIT);
    summary();
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b;
    int sum = 0;
    for (int i = 0; i < 256; i++) model[i] = (i >= 2 && i <= 62) ? i : 0;
    model[0] = 128; model[1] = 8;
    for (int i = 0; i <= 62; i++) sum += model[i];
    model[63] = sum % 256;

    tick(5);
    rst_n = 1'b1;
    tick(5);
    check(sda_oe == 1'b0, "R11", "released after reset", sda_oe, 0);

    // R2 default image and checksum at byte 63
    read_seq(0, 64, "R2");
    check(model[63] == 8'h28, "R2", "bench checksum", model[63], 8'h28);

    // R1 wrong address, then strap change
    bus_start();
    send_byte(8'hAE, ack);
    check(!ack, "R1", "foreign address nack", ack, 0);
    send_byte(8'h00, ack);
    check(!ack, "R1", "no drive after mismatch", ack, 0);
    bus_stop();
    strap = 3'b101;
    bus_start();
    send_byte(8'hAA, ack);
    check(ack, "R1", "strap 101 address ack", ack, 1);
    bus_stop();

    // R4 multi-byte write to upper half
    write_seq(8'hA0, 3, 8'h11, 8'h11, "R4");
    read_seq(8'hA0, 3, "R4");

    // R5 locked lower half
    write_seq(8'h10, 2, 8'hEE, 1, "R5");
    read_seq(8'h10, 2, "R5");

    // R6 write protect
    wp = 1'b1;
    write_seq(8'hA0, 1, 8'h99, 0, "R6");
    wp = 1'b0;
    read_seq(8'hA0, 1, "R6");

    // R7 wrap on read; write at 0xFF crosses into locked byte 0
    write_seq(8'hFE, 2, 8'hAB, 8'h22, "R7");
    write_seq(8'hFF, 2, 8'h5C, 1, "R7");
    read_seq(8'hFE, 4, "R7");

    // R3 pointer set, then current-address read
    write_seq(8'h05, 0, 0, 0, "R3");
    bus_start();
    send_byte(dev(1), ack);
    recv_byte(1'b0, b);
    check(b == 8'(model[5]), "R3", "current address read", b, model[5]);
    // R8 extra clocks after nack
    for (int k = 0; k < 9; k++) begin
      host_scl = 1'b1; tick(Q);
      check(sda_oe == 1'b0, "R8", "released after nack", sda_oe, 0);
      tick(Q); host_scl = 1'b0; tick(2 * Q);
    end
    bus_stop();

    // R9 stop inside a data byte
    bus_start();
    send_byte(dev(0), ack);
    send_byte(8'hB0, ack);
    send_bits(8'h5A, 4);
    bus_stop();
    check(sda_oe == 1'b0, "R9", "idle after stop", sda_oe, 0);
    read_seq(8'hB0, 1, "R9");

    // R10 repeated start inside a data byte
    write_seq(8'hC0, 1, 8'h77, 0, "R10");
    bus_start();
    send_byte(dev(0), ack);
    send_byte(8'hC0, ack);
    send_bits(8'h0F, 4);
    bus_start();
    send_byte(dev(1), ack);
    check(ack, "R10", "address decode after start", ack, 1);
    recv_byte(1'b0, b);
    check(b == 8'(model[8'hC0]), "R10", "pointer kept", b, model[8'hC0]);
    bus_stop();
    tick(4 * Q);

    check(viol_quiet == 0, "R11", "cycles driven while model quiet", viol_quiet, 0);
    check(viol_edge == 0, "R12", "drive asserted while scl high", viol_edge, 0);
    summary();
    $finish;
  end
endmodule